// File: doc/BRIEF.md
# Multi-Unit Selectable ALU

This block is a purely combinational 32-bit arithmetic and logic unit with a 33-bit result. A four-bit select input picks one of three internal units and one operation inside that unit. The upper two select bits pick the unit. The lower two select bits pick the operation.

The arithmetic unit uses a single adder that forms A + Y + carry-in. Y is chosen bit by bit from B, the complement of B, all ones or all zeros. This one adder covers add, add-with-carry, subtract, subtract-with-borrow, decrement, increment and transfer. The logic unit provides AND, OR, XOR and NOT. The shifter moves A by one position with zero fill.

Bit 32 of the result has a different meaning in each unit:
- arithmetic: the adder carry-out;
- shift: the bit pushed out of A;
- logic: always 0.

The block sits in an execution datapath with no clock. The result follows the inputs after the combinational delay.

Top module: `alu32_multi`

## Requirements
- R1: With sel = 4'b0000, result equals the 33-bit sum A + B + cin, and result[32] is the carry-out.
- R2: With sel = 4'b0001, result equals the 33-bit sum A + (~B) + cin. cin=1 gives A-B and cin=0 gives A-B-1.
- R3: With sel = 4'b0010, result equals A + 32'hFFFFFFFF + cin, 33 bits wide. cin=0 is a decrement and cin=1 is a transfer of A with result[32]=1.
- R4: With sel = 4'b0011, result equals A + cin, 33 bits wide. cin=0 is a transfer and cin=1 is an increment.
- R5: With sel[3:2] = 2'b01, result[31:0] depends on sel[1:0]:
  - 00: A AND B;
  - 01: A OR B;
  - 10: A XOR B;
  - 11: NOT A.
- R6: With sel[3:2] = 2'b01, result[32] is 0 and cin has no effect on result.
- R7: With sel[3] = 1 and sel[1] = 0, result is {A[0], 1'b0, A[31:1]}, a logical right shift by one whose shifted-out bit appears in result[32].
- R8: With sel[3] = 1 and sel[1] = 1, result is {A[31], A[30:0], 1'b0}, a logical left shift by one whose shifted-out bit appears in result[32].
- R9: With sel[3] = 1, the values of sel[2], sel[0], B and cin have no effect on result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand; the only operand of NOT, shifts, increment, decrement and transfer |
| b | input | 32 | Second operand |
| cin | input | 1 | Adder carry-in; used by the arithmetic unit only |
| sel | input | 4 | sel[3:2] picks the unit, sel[1:0] picks the operation |
| result | output | 33 | Selected unit output; bit 32 is carry-out, the shifted-out bit, or 0 |

## Verification
Every select code is tried with both carry-in values on each operand pair. The pairs are chosen to separate faults:
- Zero and all-ones operands separate a correct carry-out from one that is dropped or inverted, and show decrement wrap-around.
- A single top-bit operand shows whether the left shift reports the outgoing bit.
- An odd operand does the same for the right shift.
- Mixed-pattern pairs tell AND, OR and XOR apart.
- Changing cin, B and the don't-care select bits in shift and logic modes exposes any leakage into those results.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH   = 2'b00,
        UNIT_LOGIC   = 2'b01,
        UNIT_SHIFT_A = 2'b10,
        UNIT_SHIFT_B = 2'b11
    } unit_kind_e;

    typedef enum logic [1:0] {
        YSRC_B     = 2'b00,
        YSRC_NOT_B = 2'b01,
        YSRC_ONES  = 2'b10,
        YSRC_ZERO  = 2'b11
    } ysrc_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } logic_op_e;

endpackage

// File: rtl/alu32_arith_unit.sv
module alu32_arith_unit
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [1:0]   op,
    output logic [W:0]   sum
);
    logic [W-1:0] y_sel;

    always_comb begin
        unique case (ysrc_e'(op))
            YSRC_B:     y_sel = b;
            YSRC_NOT_B: y_sel = ~b;
            YSRC_ONES:  y_sel = {W{1'b1}};
            YSRC_ZERO:  y_sel = {W{1'b0}};
            default:    y_sel = {W{1'b0}};
        endcase
    end

    assign sum = {1'b0, a} + {1'b0, y_sel} + {{W{1'b0}}, cin};
endmodule

// File: rtl/alu32_logic_unit.sv
module alu32_logic_unit
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W:0]   res
);
    logic [W-1:0] bits;

    always_comb begin
        unique case (logic_op_e'(op))
            LOP_AND: bits = a & b;
            LOP_OR:  bits = a | b;
            LOP_XOR: bits = a ^ b;
            LOP_NOT: bits = ~a;
            default: bits = ~a;
        endcase
    end

    assign res = {1'b0, bits};
endmodule

// File: rtl/alu32_shift_unit.sv
module alu32_shift_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic         to_left,
    output logic [W:0]   res
);
    logic [W:0] left_res;
    logic [W:0] right_res;

    assign left_res  = {a[W-1], a[W-2:0], 1'b0};
    assign right_res = {a[0], 1'b0, a[W-1:1]};
    assign res       = to_left ? left_res : right_res;
endmodule

// File: rtl/alu32_multi.sv
module alu32_multi
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [3:0]   sel,
    output logic [W:0]   result
);
    logic [W:0] arith_res;
    logic [W:0] logic_res;
    logic [W:0] shift_res;

    alu32_arith_unit #(.W(W)) u_arith (
        .a   (a),
        .b   (b),
        .cin (cin),
        .op  (sel[1:0]),
        .sum (arith_res)
    );

    alu32_logic_unit #(.W(W)) u_logic (
        .a   (a),
        .b   (b),
        .op  (sel[1:0]),
        .res (logic_res)
    );

    alu32_shift_unit #(.W(W)) u_shift (
        .a       (a),
        .to_left (sel[1]),
        .res     (shift_res)
    );

    always_comb begin
        unique case (unit_kind_e'(sel[3:2]))
            UNIT_ARITH:   result = arith_res;
            UNIT_LOGIC:   result = logic_res;
            UNIT_SHIFT_A: result = shift_res;
            UNIT_SHIFT_B: result = shift_res;
            default:      result = shift_res;
        endcase
    end
endmodule

// File: rtl/alu32_multi_checker.sv
module alu32_multi_checker #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [3:0]   sel,
    input logic [W:0]   result
);
    always_comb begin
        if (sel == 4'b0000)
            p_add_r1: assert (result == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
        if (sel == 4'b0001)
            p_sub_r2: assert (result == ({1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin}));
        if (sel == 4'b0010)
            p_dec_r3: assert (result == ({1'b0, a} + {1'b0, {W{1'b1}}} + {{W{1'b0}}, cin}));
        if (sel == 4'b0011)
            p_inc_r4: assert (result == ({1'b0, a} + {{W{1'b0}}, cin}));
        if (sel == 4'b0111)
            p_not_r5: assert (result[W-1:0] == ~a);
        if (sel[3:2] == 2'b01)
            p_logic_top_r6: assert (result[W] == 1'b0);
        if (sel[3] && !sel[1])
            p_shr_r7: assert (result == {a[0], 1'b0, a[W-1:1]});
        if (sel[3] && sel[1])
            p_shl_r8: assert (result == {a[W-1], a[W-2:0], 1'b0});
        if (sel[3])
            p_shift_b_free_r9: assert (result[W-1:1] == (sel[1] ? a[W-2:0] : {1'b0, a[W-1:2]}));
    end
endmodule

bind alu32_multi alu32_multi_checker #(.W(W)) u_chk (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .sel    (sel),
    .result (result)
);

// File: tb/alu32_multi_bench.sv
module alu32_multi_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        cin = 1'b0;
    logic [3:0]  sel = '0;
    logic [32:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    alu32_multi u_alu32_multi (
        .a(a), .b(b), .cin(cin), .sel(sel), .result(result)
    );

    localparam logic [63:0] OPS [8] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h0000_0001},
        {32'h0000_0001, 32'h8000_0000},
        {32'h1234_5678, 32'h8765_4321},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'hA5A5_0F0F, 32'h3C3C_FF00},
        {32'h7FFF_FFFF, 32'h0000_0001}
    };

    function automatic logic [32:0] model(input logic [31:0] ma, input logic [31:0] mb,
                                          input logic mc, input logic [3:0] ms);
        logic [31:0] y;
        case (ms[3:2])
            2'b00: begin
                case (ms[1:0])
                    2'b00: y = mb;
                    2'b01: y = ~mb;
                    2'b10: y = 32'hFFFF_FFFF;
                    default: y = 32'h0;
                endcase
                return {1'b0, ma} + {1'b0, y} + {32'h0, mc};
            end
            2'b01: begin
                case (ms[1:0])
                    2'b00: return {1'b0, ma & mb};
                    2'b01: return {1'b0, ma | mb};
                    2'b10: return {1'b0, ma ^ mb};
                    default: return {1'b0, ~ma};
                endcase
            end
            default: return ms[1] ? {ma[31], ma[30:0], 1'b0} : {ma[0], 1'b0, ma[31:1]};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] ms);
        if (ms[3]) return ms[1] ? "R8" : "R7";
        if (ms[2]) return "R5";
        case (ms[1:0])
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] ta, input logic [31:0] tb_v, input logic tc,
                               input logic [3:0] ts, input logic [32:0] expv, input string req);
        @(posedge clk);
        a = ta; b = tb_v; cin = tc; sel = ts;
        @(negedge clk);
        n_checks++;
        if (result !== expv) begin
            n_fail++;
            $display("FAIL %s sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
                     req, ts, tc, ta, tb_v, result, expv);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state: all-zero inputs select the adder and give zero (R1)
        apply_check(32'h0, 32'h0, 1'b0, 4'b0000, 33'h0, "R1");

        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 2; c++) begin
                    apply_check(OPS[i][63:32], OPS[i][31:0], c[0], s[3:0],
                                model(OPS[i][63:32], OPS[i][31:0], c[0], s[3:0]),
                                req_of(s[3:0]));
                end
            end
        end

        // directed corner cases
        apply_check(32'h1234_5678, 32'h8765_4321, 1'b0, 4'b0000, 33'h0_9999_9999, "R1");
        apply_check(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'b0000, 33'h1_0000_0000, "R1");
        apply_check(32'h0000_0000, 32'h0000_0001, 1'b1, 4'b0001, 33'h0_FFFF_FFFF, "R2");
        apply_check(32'h0000_0005, 32'h0000_0003, 1'b0, 4'b0001, 33'h1_0000_0001, "R2");
        apply_check(32'h0000_0000, 32'h0, 1'b0, 4'b0010, 33'h0_FFFF_FFFF, "R3");
        apply_check(32'h1234_5678, 32'h0, 1'b1, 4'b0010, 33'h1_1234_5678, "R3");
        apply_check(32'hFFFF_FFFF, 32'h0, 1'b1, 4'b0011, 33'h1_0000_0000, "R4");
        apply_check(32'h1234_5678, 32'h0, 1'b0, 4'b0011, 33'h0_1234_5678, "R4");
        apply_check(32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 4'b0110, 33'h0_0FF0_0FF0, "R5");
        apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'b0101, 33'h0_FFFF_FFFF, "R6");
        apply_check(32'h0000_0000, 32'h0, 1'b1, 4'b0111, 33'h0_FFFF_FFFF, "R6");
        apply_check(32'h0000_0003, 32'h0, 1'b0, 4'b1000, 33'h1_0000_0001, "R7");
        apply_check(32'h8000_0001, 32'h0, 1'b0, 4'b1010, 33'h1_0000_0002, "R8");
        // shift results unaffected by sel[2], sel[0], b, cin (R9)
        apply_check(32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 4'b1111, 33'h1_0000_0002, "R9");
        apply_check(32'h0000_0003, 32'hDEAD_BEEF, 1'b1, 4'b1101, 33'h1_0000_0001, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule